// File: doc/BRIEF.md
# Programmable Raster Timing Generator

This block produces the horizontal and vertical timing for a progressive video output. A narrow register write port loads every count limit. Each limit is stored as the last count value, not as a length. The generator drives several outputs: the current pixel and line counts, a display-enable window, horizontal and vertical sync with selectable polarity, a sync-on-colour flag for the DAC, and a one-cycle early-fetch pulse. The early-fetch pulse fires at a programmed position on every line, so that memory reads for the next line can start ahead of time.

Software clears the run and refresh bits of the control register before it reloads the timing, and sets them again afterwards. While the run bit is clear, both counters sit at zero and every output stays inactive. Power saving is handled through the sync control word, which can silence the horizontal sync, the vertical sync, or both. A separate blanking bit forces the display window off and leaves the syncs running.

After reset, the block holds a 1280x1024 progressive mode. Its horizontal timing is 48 pixels of front porch, 112 pixels of sync and 248 pixels of back porch. Its vertical timing is 1 line of front porch, 3 lines of sync and 38 lines of back porch. The early-fetch point is 355 pixels before the end of the line. The generator comes out of reset stopped.

Top module: `disp_timing_gen`

## Requirements
- R1: After reset, all outputs are zero. The registers hold the default mode: horizontal last count 1687, active last 1279, hsync start 1327, hsync end 1439, fetch point 1332, vertical last count 1065, active last 1023, vsync start 1024, vsync end 1027. The control, sync control and blank registers are zero.
- R2: While control bit 0 (run) is clear, `pix_x` and `line_y` read zero, `de` and `fetch_pulse` are low, and each sync sits at its inactive level.
- R3: While running, `pix_x` steps by one per cycle up to the horizontal last count, then returns to zero. `line_y` steps by one on that return, and it goes back to zero after the vertical last count.
- R4: `de` is high only while running, with `pix_x` ≤ horizontal active last and `line_y` ≤ vertical active last, and with control bit 1 (refresh) set.
- R5: Hsync is active when `pix_x` is above hsync start and at or below hsync end. Sync control bit 3 inverts it, and the inactive level equals that bit.
- R6: Vsync is active when `line_y` is above vsync start and at or below vsync end. Sync control bit 4 inverts it.
- R7: Sync control bit 5 holds hsync at its inactive level, bit 6 does the same for vsync, and bit 1 does it for both. Each suppression is applied after the polarity inversion.
- R8: `sync_on_rgb` follows sync control bit 0.
- R9: While running, `fetch_pulse` is high for exactly the cycle in which `pix_x` equals the fetch point, on every line, including a fetch point equal to the horizontal last count.
- R10: Blank register bit 0 forces `de` low and leaves hsync, vsync and the counters unchanged.
- R11: The write port takes `wr_addr` and loads `wr_data` on a cycle with `wr_en` high. The addresses are: 0 control, 1 sync control, 2 blank, 3 horizontal last count, 4 horizontal active last, 5 hsync start, 6 hsync end, 7 fetch point, 8 vertical last count, 9 vertical active last, 10 vsync start, 11 vsync end. Limits take the low `CNT_W` bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | AW (4) | Register address |
| wr_data | input | 32 | Register write data |
| pix_x | output | CNT_W (12) | Current pixel count |
| line_y | output | CNT_W (12) | Current line count |
| de | output | 1 | Display-enable window |
| hsync | output | 1 | Horizontal sync, polarity applied |
| vsync | output | 1 | Vertical sync, polarity applied |
| sync_on_rgb | output | 1 | Sync-on-colour flag |
| fetch_pulse | output | 1 | One-cycle early line fetch strike |

## Verification
The early-fetch pulse and the line wrap can land in the same cycle. The bench provokes this by programming the fetch point equal to the horizontal last count, with the hsync window also ending on that pixel. In that cycle it expects three things: the pulse on the final pixel, the end of hsync, and the advance of `line_y` on the next sample. A second collision happens when the horizontal and vertical wraps coincide at the end of a frame, where both counters must return to zero together. The bench judges every cycle of whole frames against an arithmetic model of the windows.

// File: rtl/dtg_pkg.sv
package dtg_pkg;

  // register addresses
  localparam int unsigned ADDR_CTRL  = 0;
  localparam int unsigned ADDR_SYNC  = 1;
  localparam int unsigned ADDR_BLANK = 2;
  localparam int unsigned ADDR_LIM0  = 3;

  // limit slots, in address order from ADDR_LIM0
  typedef enum int unsigned {
    L_HLAST  = 0,
    L_HACT   = 1,
    L_HSBEG  = 2,
    L_HSEND  = 3,
    L_FETCH  = 4,
    L_VLAST  = 5,
    L_VACT   = 6,
    L_VSBEG  = 7,
    L_VSEND  = 8
  } lim_slot_e;

  localparam int unsigned NUM_LIM = 9;

  // bit positions
  localparam int unsigned CB_RUN     = 0;
  localparam int unsigned CB_REFRESH = 1;
  localparam int unsigned SB_SOR     = 0;
  localparam int unsigned SB_ALLOFF  = 1;
  localparam int unsigned SB_HINV    = 3;
  localparam int unsigned SB_VINV    = 4;
  localparam int unsigned SB_HOFF    = 5;
  localparam int unsigned SB_VOFF    = 6;
  localparam int unsigned SYNC_W     = 7;

  typedef struct packed {
    logic run;
    logic refresh;
    logic blank;
    logic sor;
    logic h_inv;
    logic v_inv;
    logic h_kill;
    logic v_kill;
  } dtg_flags_t;

endpackage

// File: rtl/dtg_regs.sv
module dtg_regs
  import dtg_pkg::*;
#(
  parameter int unsigned CNT_W    = 12,
  parameter int unsigned AW       = 4,
  parameter int unsigned DW       = 32,
  parameter int unsigned H_ACTIVE = 1280,
  parameter int unsigned H_FP     = 48,
  parameter int unsigned H_SW     = 112,
  parameter int unsigned H_BP     = 248,
  parameter int unsigned V_ACTIVE = 1024,
  parameter int unsigned V_FP     = 1,
  parameter int unsigned V_SW     = 3,
  parameter int unsigned V_BP     = 38,
  parameter int unsigned PREFETCH = 355
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_addr,
  input  logic [DW-1:0]    wr_data,
  output logic [CNT_W-1:0] lim [NUM_LIM],
  output dtg_flags_t       flags
);

  localparam int unsigned H_TOTAL = H_ACTIVE + H_FP + H_SW + H_BP;
  localparam int unsigned V_TOTAL = V_ACTIVE + V_FP + V_SW + V_BP;
  localparam int unsigned PF_CAP  = (PREFETCH >= H_TOTAL) ? (H_TOTAL - 1) : PREFETCH;

  function automatic logic [CNT_W-1:0] default_of(input int unsigned slot);
    int unsigned v;
    case (slot)
      L_HLAST: v = H_TOTAL - 1;
      L_HACT:  v = H_ACTIVE - 1;
      L_HSBEG: v = H_ACTIVE + H_FP - 1;
      L_HSEND: v = H_ACTIVE + H_FP + H_SW - 1;
      L_FETCH: v = H_TOTAL - PF_CAP - 1;
      L_VLAST: v = V_TOTAL - 1;
      L_VACT:  v = V_ACTIVE - 1;
      L_VSBEG: v = V_ACTIVE + V_FP - 1;
      default: v = V_ACTIVE + V_FP + V_SW - 1;
    endcase
    return CNT_W'(v);
  endfunction

  logic [1:0]        ctrl_q;
  logic [SYNC_W-1:0] sync_q;
  logic              blank_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q  <= '0;
      sync_q  <= '0;
      blank_q <= 1'b0;
    end else if (wr_en) begin
      if (wr_addr == AW'(ADDR_CTRL))  ctrl_q  <= wr_data[1:0];
      if (wr_addr == AW'(ADDR_SYNC))  sync_q  <= wr_data[SYNC_W-1:0];
      if (wr_addr == AW'(ADDR_BLANK)) blank_q <= wr_data[0];
    end
  end

  for (genvar i = 0; i < NUM_LIM; i++) begin : g_lim
    logic [CNT_W-1:0] q;
    always_ff @(posedge clk) begin
      if (rst)
        q <= default_of(i);
      else if (wr_en && wr_addr == AW'(ADDR_LIM0 + i))
        q <= wr_data[CNT_W-1:0];
    end
    assign lim[i] = q;
  end

  always_comb begin
    flags.run     = ctrl_q[CB_RUN];
    flags.refresh = ctrl_q[CB_REFRESH];
    flags.blank   = blank_q;
    flags.sor     = sync_q[SB_SOR];
    flags.h_inv   = sync_q[SB_HINV];
    flags.v_inv   = sync_q[SB_VINV];
    flags.h_kill  = sync_q[SB_HOFF] | sync_q[SB_ALLOFF];
    flags.v_kill  = sync_q[SB_VOFF] | sync_q[SB_ALLOFF];
  end

endmodule

// File: rtl/dtg_counter.sv
module dtg_counter #(
  parameter int unsigned CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [CNT_W-1:0] h_last,
  input  logic [CNT_W-1:0] v_last,
  output logic [CNT_W-1:0] h_cnt,
  output logic [CNT_W-1:0] v_cnt,
  output logic             live
);

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      h_cnt <= '0;
      v_cnt <= '0;
      live  <= 1'b0;
    end else begin
      live <= 1'b1;
      if (h_cnt >= h_last) begin
        h_cnt <= '0;
        v_cnt <= (v_cnt >= v_last) ? '0 : v_cnt + 1'b1;
      end else begin
        h_cnt <= h_cnt + 1'b1;
      end
    end
  end

endmodule

// File: rtl/dtg_outstage.sv
module dtg_outstage
  import dtg_pkg::*;
#(
  parameter int unsigned CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             live,
  input  logic [CNT_W-1:0] h_cnt,
  input  logic [CNT_W-1:0] v_cnt,
  input  logic [CNT_W-1:0] lim [NUM_LIM],
  input  dtg_flags_t       flags,
  output logic [CNT_W-1:0] pix_x,
  output logic [CNT_W-1:0] line_y,
  output logic             de,
  output logic             hsync,
  output logic             vsync,
  output logic             sync_on_rgb,
  output logic             fetch_pulse
);

  logic h_vis, v_vis, h_win, v_win, h_on, v_on, f_hit;

  always_comb begin
    h_vis = h_cnt <= lim[L_HACT];
    v_vis = v_cnt <= lim[L_VACT];
    h_win = (h_cnt > lim[L_HSBEG]) && (h_cnt <= lim[L_HSEND]);
    v_win = (v_cnt > lim[L_VSBEG]) && (v_cnt <= lim[L_VSEND]);
    h_on  = live && h_win && !flags.h_kill;
    v_on  = live && v_win && !flags.v_kill;
    f_hit = live && (h_cnt == lim[L_FETCH]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pix_x       <= '0;
      line_y      <= '0;
      de          <= 1'b0;
      hsync       <= 1'b0;
      vsync       <= 1'b0;
      sync_on_rgb <= 1'b0;
      fetch_pulse <= 1'b0;
    end else begin
      pix_x       <= h_cnt;
      line_y      <= v_cnt;
      de          <= live && h_vis && v_vis && flags.refresh && !flags.blank;
      hsync       <= h_on ^ flags.h_inv;
      vsync       <= v_on ^ flags.v_inv;
      sync_on_rgb <= flags.sor;
      fetch_pulse <= f_hit;
    end
  end

endmodule

// File: rtl/disp_timing_gen.sv
module disp_timing_gen
  import dtg_pkg::*;
#(
  parameter int unsigned CNT_W    = 12,
  parameter int unsigned AW       = 4,
  parameter int unsigned DW       = 32,
  parameter int unsigned H_ACTIVE = 1280,
  parameter int unsigned H_FP     = 48,
  parameter int unsigned H_SW     = 112,
  parameter int unsigned H_BP     = 248,
  parameter int unsigned V_ACTIVE = 1024,
  parameter int unsigned V_FP     = 1,
  parameter int unsigned V_SW     = 3,
  parameter int unsigned V_BP     = 38,
  parameter int unsigned PREFETCH = 355
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_addr,
  input  logic [DW-1:0]    wr_data,
  output logic [CNT_W-1:0] pix_x,
  output logic [CNT_W-1:0] line_y,
  output logic             de,
  output logic             hsync,
  output logic             vsync,
  output logic             sync_on_rgb,
  output logic             fetch_pulse
);

  logic [CNT_W-1:0] lim [NUM_LIM];
  dtg_flags_t       flags;
  logic [CNT_W-1:0] h_cnt, v_cnt;
  logic             live;

  // exposed to the bound checker
  logic ctl_run, hs_kill, hs_inv, vs_kill, vs_inv, blank_on;
  assign ctl_run  = flags.run;
  assign hs_kill  = flags.h_kill;
  assign hs_inv   = flags.h_inv;
  assign vs_kill  = flags.v_kill;
  assign vs_inv   = flags.v_inv;
  assign blank_on = flags.blank;

  dtg_regs #(
    .CNT_W(CNT_W), .AW(AW), .DW(DW),
    .H_ACTIVE(H_ACTIVE), .H_FP(H_FP), .H_SW(H_SW), .H_BP(H_BP),
    .V_ACTIVE(V_ACTIVE), .V_FP(V_FP), .V_SW(V_SW), .V_BP(V_BP),
    .PREFETCH(PREFETCH)
  ) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .lim(lim), .flags(flags)
  );

  dtg_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .run(flags.run),
    .h_last(lim[L_HLAST]), .v_last(lim[L_VLAST]),
    .h_cnt(h_cnt), .v_cnt(v_cnt), .live(live)
  );

  dtg_outstage #(.CNT_W(CNT_W)) u_out (
    .clk(clk), .rst(rst), .live(live), .h_cnt(h_cnt), .v_cnt(v_cnt),
    .lim(lim), .flags(flags),
    .pix_x(pix_x), .line_y(line_y), .de(de), .hsync(hsync),
    .vsync(vsync), .sync_on_rgb(sync_on_rgb), .fetch_pulse(fetch_pulse)
  );

endmodule

// File: rtl/dtg_checker.sv
module dtg_checker #(
  parameter int unsigned CNT_W = 12
) (
  input logic             clk,
  input logic             rst,
  input logic [CNT_W-1:0] pix_x,
  input logic [CNT_W-1:0] line_y,
  input logic             de,
  input logic             hsync,
  input logic             vsync,
  input logic             ctl_run,
  input logic             hs_kill,
  input logic             hs_inv,
  input logic             vs_kill,
  input logic             vs_inv,
  input logic             blank_on
);

  // R3: a nonzero pixel count always follows its predecessor
  a_r3_pix_step: assert property (@(posedge clk) disable iff (rst)
    (pix_x != '0) |-> (pix_x == $past(pix_x) + 1'b1));

  // R3: the line count only moves where the pixel count is zero
  a_r3_line_on_wrap: assert property (@(posedge clk) disable iff (rst)
    (line_y != $past(line_y)) |-> (pix_x == '0));

  // R2: two cycles after a stopped run bit the counts read zero
  a_r2_hold_zero: assert property (@(posedge clk) disable iff (rst)
    !$past(ctl_run, 2) |-> (pix_x == '0 && line_y == '0 && !de));

  // R7: suppressed syncs sit at the polarity-defined idle level
  a_r7_hs_idle: assert property (@(posedge clk) disable iff (rst)
    $past(hs_kill) |-> (hsync == $past(hs_inv)));

  a_r7_vs_idle: assert property (@(posedge clk) disable iff (rst)
    $past(vs_kill) |-> (vsync == $past(vs_inv)));

  // R10: blanking keeps the display window closed
  a_r10_blank: assert property (@(posedge clk) disable iff (rst)
    $past(blank_on) |-> !de);

endmodule

bind disp_timing_gen dtg_checker #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .pix_x(pix_x), .line_y(line_y), .de(de),
  .hsync(hsync), .vsync(vsync), .ctl_run(ctl_run), .hs_kill(hs_kill),
  .hs_inv(hs_inv), .vs_kill(vs_kill), .vs_inv(vs_inv), .blank_on(blank_on)
);

// File: tb/tb_disp_timing_gen.sv
module tb_disp_timing_gen;

  localparam int CNT_W = 12;
  localparam int AW    = 4;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             wr_en = 1'b0;
  logic [AW-1:0]    wr_addr = '0;
  logic [31:0]      wr_data = '0;
  logic [CNT_W-1:0] pix_x, line_y;
  logic             de, hsync, vsync, sync_on_rgb, fetch_pulse;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  always #2 clk = ~clk;

  disp_timing_gen dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .pix_x(pix_x), .line_y(line_y), .de(de), .hsync(hsync), .vsync(vsync),
    .sync_on_rgb(sync_on_rgb), .fetch_pulse(fetch_pulse)
  );

  // bench model of programmed state
  int b_ht, b_ha, b_hss, b_hse, b_hf, b_vt, b_va, b_vss, b_vse;
  bit b_run, b_ref, b_blank, b_sor, b_hinv, b_vinv, b_hoff, b_voff, b_alloff;
  bit have_prev;
  int prev_h, prev_v;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d (x=%0d y=%0d)", tag, act, exp, pix_x, line_y);
    end
  endtask

  task automatic wr(input int addr, input int data);
    @(posedge clk); #1;
    wr_en = 1'b1; wr_addr = AW'(addr); wr_data = 32'(data);
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic set_ctrl(input bit run, input bit refr);
    b_run = run; b_ref = refr;
    wr(0, {30'd0, refr, run});
  endtask

  task automatic set_sync(input int v);
    b_sor = v[0]; b_alloff = v[1]; b_hinv = v[3]; b_vinv = v[4];
    b_hoff = v[5]; b_voff = v[6];
    wr(1, v);
  endtask

  task automatic set_blank(input bit b);
    b_blank = b;
    wr(2, {31'd0, b});
  endtask

  task automatic set_limits(input int ht, ha, hss, hse, hf, vt, va, vss, vse);
    b_ht = ht; b_ha = ha; b_hss = hss; b_hse = hse; b_hf = hf;
    b_vt = vt; b_va = va; b_vss = vss; b_vse = vse;
    wr(3, ht); wr(4, ha); wr(5, hss); wr(6, hse); wr(7, hf);
    wr(8, vt); wr(9, va); wr(10, vss); wr(11, vse);
  endtask

  task automatic settle();
    repeat (3) @(posedge clk);
    #1;
    have_prev = 0;
  endtask

  task automatic check_cycle();
    int h, v, eh, ev;
    bit ede, ehs, evs, ef;
    h = int'(pix_x); v = int'(line_y);
    if (!b_run) begin
      chk(h == 0 && v == 0, "R2 counts held", h, 0);
    end else if (have_prev) begin
      if (prev_h >= b_ht) begin
        eh = 0; ev = (prev_v >= b_vt) ? 0 : prev_v + 1;
      end else begin
        eh = prev_h + 1; ev = prev_v;
      end
      chk(h == eh, "R3 pixel count", h, eh);
      chk(v == ev, "R3 line count", v, ev);
    end
    ede = b_run && h <= b_ha && v <= b_va && b_ref && !b_blank;
    ehs = b_hinv ^ (b_run && h > b_hss && h <= b_hse && !b_hoff && !b_alloff);
    evs = b_vinv ^ (b_run && v > b_vss && v <= b_vse && !b_voff && !b_alloff);
    ef  = b_run && h == b_hf;
    chk(de == ede, b_blank ? "R10 blank de" : "R4 de window", de, ede);
    chk(hsync == ehs, (b_hoff || b_alloff) ? "R7 hsync off" : "R5 hsync", hsync, ehs);
    chk(vsync == evs, (b_voff || b_alloff) ? "R7 vsync off" : "R6 vsync", vsync, evs);
    chk(fetch_pulse == ef, "R9 fetch pulse", fetch_pulse, ef);
    chk(sync_on_rgb == b_sor, "R8 sync on rgb", sync_on_rgb, b_sor);
    prev_h = h; prev_v = v; have_prev = 1;
  endtask

  task automatic run_cycles(input int n);
    for (int i = 0; i < n; i++) begin
      check_cycle();
      @(posedge clk); #1;
    end
  endtask

  localparam int FRAME = 20 * 10 + 10;

  initial begin
    b_run = 0; b_ref = 0; b_blank = 0;
    b_sor = 0; b_alloff = 0; b_hinv = 0; b_vinv = 0; b_hoff = 0; b_voff = 0;
    // R1 / R11 defaults of the register file
    b_ht = 1687; b_ha = 1279; b_hss = 1327; b_hse = 1439; b_hf = 1332;
    b_vt = 1065; b_va = 1023; b_vss = 1024; b_vse = 1027;
    have_prev = 0;
    repeat (4) @(posedge clk);
    #1 rst = 1'b0;
    @(posedge clk); #1;
    // R1 reset state at the ports
    chk(pix_x == 0 && line_y == 0, "R1 reset counts", pix_x, 0);
    chk(!de && !hsync && !vsync && !fetch_pulse && !sync_on_rgb, "R1 reset outputs",
        {de, hsync, vsync, fetch_pulse, sync_on_rgb}, 0);
    run_cycles(10);  // R2 stopped after reset

    // R1 default mode: run past one default line
    set_ctrl(1, 1); settle();
    run_cycles(1800);

    // small mode, normal polarity
    set_ctrl(0, 0); settle();
    set_limits(19, 11, 13, 16, 15, 9, 5, 6, 7);
    set_sync(0); set_ctrl(1, 1); settle();
    run_cycles(FRAME);

    // R5 R6 R8 inverted polarity with sync on rgb
    set_sync(32'h19); settle();
    run_cycles(FRAME);

    // R7 each suppression, with and without inversion
    set_sync(32'h20); settle(); run_cycles(FRAME);
    set_sync(32'h40); settle(); run_cycles(FRAME);
    set_sync(32'h02); settle(); run_cycles(FRAME);
    set_sync(32'h78); settle(); run_cycles(FRAME);

    // R10 blank keeps syncs running
    set_sync(32'h08); set_blank(1); settle(); run_cycles(FRAME);
    set_blank(0);

    // R4 refresh bit clear: counters run, window closed
    set_ctrl(1, 0); settle(); run_cycles(FRAME);

    // R9 fetch at the last pixel, hsync ending on the wrap
    set_ctrl(0, 0); settle();
    set_limits(15, 9, 11, 15, 15, 7, 4, 5, 7);
    set_sync(0); set_ctrl(1, 1); settle();
    run_cycles(16 * 8 * 2 + 5);

    // R2 stop again and hold zero
    set_sync(32'h18); set_ctrl(0, 1); settle();
    run_cycles(20);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule